// File: doc/BRIEF.md
# Three-Level Interrupt Priority Controller

This block arbitrates thirteen interrupt sources into a single vector request for a microcontroller core. One of them is a power-fail source that always sits on the top level. The other twelve each carry a software priority bit that puts them on the high or the low level. Inside a level the source with the smallest index wins, so the classic sources take the low indices and the newer ones rank below them.

The controller remembers which levels are being serviced. A pending source is granted only when its level is strictly above every level that is already in service, so only a more urgent level can preempt a running handler. The core answers a request with an acknowledge pulse, which marks the granted level as in service. A return pulse releases the most urgent level in service. The power-fail source has a sticky flag. A power-fail event sets it whatever the enable says, and only an explicit clear input takes it down.

Top module: `irq_prio_ctrl`

## Requirements
- R1: During and right after reset, no level is in service (`in_svc` = 0) and the power-fail flag is 0, even when `pf_event` is held high.
- R2: `irq_req` is 1 only while `glob_en` is 1. `irq_vec` is 0 for the power-fail source and k+1 for regular source k.
- R3: When `pf_flag` and `pf_en` are both 1, the power-fail source wins over every regular source. `irq_lvl` encodes power-fail as 3, high as 2 and low as 1.
- R4: An enabled pending source with its `src_hi` bit set wins over every low-level source, whatever their indices.
- R5: Among the candidates of one level, the lowest source index wins.
- R6: A pending source whose `src_en` bit is 0 never contributes to the request or the vector.
- R7: A request is raised only when the winning level is strictly greater than the highest level in service.
- R8: `ack` while `irq_req` is 1 sets the `in_svc` bit of the granted level on the next cycle (bit 2 power-fail, bit 1 high, bit 0 low). `ack` without a request leaves `in_svc` unchanged.
- R9: `reti` clears the highest set bit of `in_svc` on the next cycle. It has no effect when `in_svc` is 0. When `reti` and an accepted `ack` arrive together, the clear happens first and then the granted bit is set.
- R10: `pf_event` sets `pf_flag` on the next cycle regardless of `pf_en`. The flag then holds until `pf_clr` is applied. If the event and the clear arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | NSRC | Pending flags of the regular sources |
| src_en | input | NSRC | Per-source enables |
| src_hi | input | NSRC | Per-source priority bit, 1 means high level |
| glob_en | input | 1 | Global interrupt enable |
| pf_event | input | 1 | Power-fail condition pulse |
| pf_clr | input | 1 | Clears the power-fail flag |
| pf_en | input | 1 | Power-fail interrupt enable |
| ack | input | 1 | Core accepts the current request |
| reti | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Winning vector index |
| irq_lvl | output | 2 | Level of the winning source |
| in_svc | output | 3 | In-service bits: power-fail, high, low |
| pf_flag | output | 1 | Sticky power-fail flag |

## Verification
The directed patterns come first. They put two sources on the same level, so that only the index order can pick the winner. Then they set a low-index source on the low level against a high-index source on the high level, which separates level priority from index priority. They also hold pending sources with their enables off, and they raise a request on a level that is already in service, so that preemption is only possible strictly upward. Further directed steps pair `reti` with `ack`, assert `pf_event` while `pf_en` is 0, and drive `pf_event` and `pf_clr` together. These expose errors in the order of the in-service updates and in flag precedence. After that, long random runs with sparse pending sets and random enable, priority, acknowledge and return pulses build nested in-service states. Each state is compared against a model that scores candidates numerically.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    LV_NONE = 2'd0,
    LV_LOW  = 2'd1,
    LV_HIGH = 2'd2,
    LV_PF   = 2'd3
  } lvl_e;

  // Highest level currently in service.
  function automatic lvl_e svc_top_of(input logic [2:0] s);
    if (s[2])      return LV_PF;
    else if (s[1]) return LV_HIGH;
    else if (s[0]) return LV_LOW;
    else           return LV_NONE;
  endfunction

  // In-service set after releasing the most urgent level.
  function automatic logic [2:0] svc_release(input logic [2:0] s);
    logic [2:0] r;
    r = s;
    if (s[2])      r[2] = 1'b0;
    else if (s[1]) r[1] = 1'b0;
    else           r[0] = 1'b0;
    return r;
  endfunction

  // In-service set after marking a granted level.
  function automatic logic [2:0] svc_mark(input logic [2:0] s, input lvl_e l);
    logic [2:0] r;
    r = s;
    case (l)
      LV_PF:   r[2] = 1'b1;
      LV_HIGH: r[1] = 1'b1;
      LV_LOW:  r[0] = 1'b1;
      default: r = s;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int N  = 12,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest set index wins: scan downward so the last hit is the smallest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_fire,
  input  lvl_e       ack_lvl,
  input  logic       reti,
  output logic [2:0] svc,
  output lvl_e       svc_top
);
  logic [2:0] svc_nxt;

  always_comb begin
    svc_nxt = reti ? svc_release(svc) : svc;
    if (ack_fire) svc_nxt = svc_mark(svc_nxt, ack_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc <= 3'b000;
    else        svc <= svc_nxt;
  end

  assign svc_top = svc_top_of(svc);
endmodule

// File: rtl/irq_pf_flag.sv
module irq_pf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NSRC  = 12,
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int VEC_W = $clog2(NSRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_pend,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             glob_en,
  input  logic             pf_event,
  input  logic             pf_clr,
  input  logic             pf_en,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [1:0]       irq_lvl,
  output logic [2:0]       in_svc,
  output logic             pf_flag
);
  // Named internal events, observed by the bound checker.
  logic [NSRC-1:0] live_src;
  logic [NSRC-1:0] lvl_cand  [2];
  logic            lvl_found [2];
  logic [IW-1:0]   lvl_idx   [2];
  logic            pf_live;
  lvl_e            best_lvl;
  lvl_e            svc_top;
  logic            ack_fire;

  assign live_src    = src_pend & src_en;
  assign lvl_cand[0] = live_src & ~src_hi;
  assign lvl_cand[1] = live_src & src_hi;

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    irq_level_pick #(.N(NSRC), .IW(IW)) u_pick (
      .cand  (lvl_cand[g]),
      .found (lvl_found[g]),
      .idx   (lvl_idx[g])
    );
  end

  irq_pf_flag u_pf (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (pf_event),
    .clr_i (pf_clr),
    .flag  (pf_flag)
  );

  assign pf_live = pf_flag & pf_en;

  always_comb begin
    best_lvl = LV_NONE;
    irq_vec  = '0;
    if (pf_live) begin
      best_lvl = LV_PF;
    end else if (lvl_found[1]) begin
      best_lvl = LV_HIGH;
      irq_vec  = VEC_W'(lvl_idx[1]) + VEC_W'(1);
    end else if (lvl_found[0]) begin
      best_lvl = LV_LOW;
      irq_vec  = VEC_W'(lvl_idx[0]) + VEC_W'(1);
    end
  end

  assign irq_lvl  = best_lvl;
  assign irq_req  = glob_en && (best_lvl != LV_NONE) && (best_lvl > svc_top);
  assign ack_fire = ack & irq_req;

  irq_svc_track u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_fire (ack_fire),
    .ack_lvl  (best_lvl),
    .reti     (reti),
    .svc      (in_svc),
    .svc_top  (svc_top)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 12,
  localparam int VEC_W = $clog2(NSRC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_pend,
  input logic [NSRC-1:0]  src_en,
  input logic             glob_en,
  input logic             pf_event,
  input logic             pf_clr,
  input logic             ack,
  input logic             reti,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic [1:0]       irq_lvl,
  input logic [2:0]       in_svc,
  input logic             pf_flag,
  input lvl_e             svc_top
);
  logic [NSRC-1:0] chk_live;
  assign chk_live = src_pend & src_en;

  a_r2_req_needs_glob: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glob_en);

  a_r6_vec_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec != '0) |-> chk_live[irq_vec - VEC_W'(1)]);

  a_r7_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > 2'(svc_top)));

  a_r8_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> in_svc[$past(irq_lvl) - 2'd1]);

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !reti) |=> $stable(in_svc));

  a_r9_reti_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(ack && irq_req) && in_svc != 3'b000)
      |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));

  a_r10_pf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pf_event |=> pf_flag);

  a_r10_pf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_flag && !pf_clr) |=> pf_flag);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  localparam int NSRC = 12;
  localparam int VW   = $clog2(NSRC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_pend = '0, src_en = '0, src_hi = '0;
  logic glob_en = 1'b0, pf_event = 1'b0, pf_clr = 1'b0, pf_en = 1'b0;
  logic ack = 1'b0, reti = 1'b0;
  logic irq_req;
  logic [VW-1:0] irq_vec;
  logic [1:0] irq_lvl;
  logic [2:0] in_svc;
  logic pf_flag;

  int checks = 0, fails = 0;
  logic [2:0] m_svc = 3'b000;
  logic       m_pf  = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC)) u_irq_prio_ctrl (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Score every candidate: level dominates, smaller index breaks ties.
  function automatic logic [7:0] model_grant();
    int best = -1, bvec = 0, lvl, top;
    if (m_pf && pf_en) begin best = 399; bvec = 0; end
    for (int k = 0; k < NSRC; k++) begin
      if (src_pend[k] && src_en[k]) begin
        int s = (src_hi[k] ? 200 : 100) + (99 - k);
        if (s > best) begin best = s; bvec = k + 1; end
      end
    end
    lvl = (best < 0) ? 0 : best / 100;
    top = m_svc[2] ? 3 : m_svc[1] ? 2 : m_svc[0] ? 1 : 0;
    return {(glob_en && lvl > top), 1'b0, 2'(lvl), 4'(bvec)};
  endfunction

  task automatic step(input string tag, input logic [NSRC-1:0] p, e, h,
                      input logic g, pe, pev, pc, a, r);
    logic [7:0] gr;
    logic [2:0] ns;
    @(negedge clk);
    src_pend = p; src_en = e; src_hi = h; glob_en = g;
    pf_en = pe; pf_event = pev; pf_clr = pc; ack = a; reti = r;
    #1;
    gr = model_grant();
    check({tag, " R2 R7 req"}, irq_req, gr[7]);
    if (gr[7]) begin
      check({tag, " R3 R4 lvl"}, irq_lvl, gr[5:4]);
      check({tag, " R5 vec"}, irq_vec, gr[3:0]);
    end
    check({tag, " R8 R9 svc"}, in_svc, m_svc);
    check({tag, " R10 pf"}, pf_flag, m_pf);
    ns = m_svc;
    if (r) begin
      if (ns[2]) ns[2] = 0; else if (ns[1]) ns[1] = 0; else ns[0] = 0;
    end
    if (a && gr[7]) ns[gr[5:4] - 2'd1] = 1'b1;
    @(posedge clk);
    m_svc = ns;
    m_pf  = pev ? 1'b1 : (pc ? 1'b0 : m_pf);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    pf_event = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 svc in reset", in_svc, 0);
    check("R1 pf in reset", pf_flag, 0);
    @(negedge clk);
    pf_event = 1'b0;
    rst_n = 1'b1;
    #1;
    check("R1 svc after reset", in_svc, 0);
    check("R1 pf after reset", pf_flag, 0);
    // Directed corners (NSRC-bit masks, bit k = source k).
    step("R6 disabled", '1, '0, '0, 1, 0, 0, 0, 0, 0);
    step("R2 global off", 12'h008, '1, '0, 0, 0, 0, 0, 0, 0);
    step("R5 same level", 12'h088, '1, '0, 1, 0, 0, 0, 0, 0);
    step("R4 high beats low", 12'h204, '1, 12'h200, 1, 0, 0, 0, 0, 0);
    step("R8 ack high", 12'h204, '1, 12'h200, 1, 0, 0, 0, 1, 0);
    step("R7 same level blocked", 12'h001, '1, 12'h001, 1, 0, 0, 0, 1, 0);
    step("R10 event while disabled", 12'h000, '1, '0, 1, 0, 1, 0, 0, 0);
    step("R3 pf preempts", 12'h001, '1, 12'h001, 1, 1, 0, 0, 1, 0);
    step("R7 pf in service", 12'h001, '1, 12'h001, 1, 1, 0, 0, 0, 1);
    step("R9 reti with ack", 12'h000, '1, '0, 1, 1, 0, 0, 1, 1);
    step("R9 reti release", 12'h000, '1, '0, 1, 0, 0, 1, 0, 1);
    step("R10 event beats clear", 12'h000, '1, '0, 1, 1, 1, 1, 0, 0);
    step("R10 held", 12'h000, '1, '0, 1, 1, 0, 0, 0, 1);
    step("R9 reti empty", 12'h000, '1, '0, 1, 0, 0, 1, 0, 1);
    step("R9 reti empty again", 12'h000, '1, '0, 1, 0, 0, 0, 0, 1);
    // Constrained random.
    for (int n = 0; n < 3000; n++) begin
      logic [NSRC-1:0] p;
      p = NSRC'($urandom) & NSRC'($urandom) & NSRC'($urandom);
      step("random", p, NSRC'($urandom) | NSRC'($urandom), NSRC'($urandom),
           ($urandom % 10) != 0, $urandom % 2, ($urandom % 20) == 0,
           ($urandom % 10) == 0, ($urandom % 10) < 3, ($urandom % 4) == 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule